// File: doc/BRIEF.md
# Vector Length Control Register Unit

This block holds the two length registers that a scalar core needs to run vector-style loops: a run-time adjustable ceiling on the vector length, and the current vector length. Software reaches them through a single-cycle CSR request port. The port supports swap, set-bits and clear-bits operations, each in a register-operand form and a 5-bit immediate form. It serves three addresses.

One address reaches the ceiling register. The other two both reach the same current-length register, but they answer differently:

- **Primary alias.** Every write is clamped to the ceiling, and the value returned is the new, clamped length. The destination register therefore always matches what was stored. When the request is within the ceiling, it is stored exactly as requested.
- **Shadow alias.** It behaves like an ordinary CSR and returns the value held before the write. This lets a context switch save and restore the length with one swap.

The ceiling itself can never exceed the register width XLEN. Lowering the ceiling also pulls the current length down in the same cycle.

Requests are taken on a clock edge when `req_valid` is high. The response appears one cycle later on registered outputs.

Top module: `vl_csr_unit`

## Requirements
- R1: After synchronous reset the ceiling reads XLEN, the current length reads 1, and `rsp_valid` and `rsp_illegal` are low.
- R2: A write through the primary alias (address `ADDR_LEN`) stores MIN(new value, ceiling) and returns that same stored value on `rsp_rdata`. A request at or below the ceiling is stored unchanged.
- R3: An access through the shadow alias (address `ADDR_LEN_SHADOW`) returns the current length held before the access. A write through it stores MIN(new value, ceiling) into the same register the primary alias uses.
- R4: A write to the ceiling (address `ADDR_MAXLEN`) stores MIN(new value, XLEN) and returns the previous ceiling.
- R5: When a ceiling write leaves the ceiling below the current length, the current length becomes the new ceiling in the same cycle. At all times the current length never exceeds the ceiling.
- R6: Set-bits computes current OR operand and clear-bits computes current AND NOT operand. Both use the register's present contents, and the clamps of R2 to R4 apply to the result afterwards.
- R7: Set-bits or clear-bits with a zero operand changes no state. It returns the ceiling, the current length, or the current length for the ceiling, primary and shadow addresses respectively. Swap always writes.
- R8: Operation codes on `req_op`: 3'b001 swap, 3'b010 set-bits, 3'b011 clear-bits take `req_wdata`; 3'b101, 3'b110, 3'b111 are the same operations taking `req_imm` zero-extended from 5 bits, so an immediate can request at most 31.
- R9: A request to any other address, or with op code 3'b000 or 3'b100, raises `rsp_illegal`, returns zero and changes no register.
- R10: `rsp_valid` is high exactly in the cycle after a cycle in which `req_valid` was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 12 | CSR address |
| req_op | input | 3 | Operation code (R8) |
| req_wdata | input | XLEN | Register-form operand |
| req_imm | input | 5 | Immediate-form operand |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | XLEN | Read result |
| rsp_illegal | output | 1 | Request addressed nothing or used a reserved op code |

## Verification
The bench sweeps every pairing of ceiling and requested length in a 16-bit configuration. Requests go to one above XLEN and beyond.

A design that returned the old length on the primary alias would break the equality between the returned value and the stored length. A design that clamped below the request would fail on requests under the ceiling. A design that skipped the pull-down on a ceiling write would show a stale length through the shadow alias.

Every 5-bit immediate is applied with garbage on the register operand, which catches an operand mux that picks the wrong source. Set and clear with a zero operand, reserved op codes and stray addresses are each followed by read-backs, which expose any hidden write.

// File: rtl/vl_csr_pkg.sv
package vl_csr_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'b000,
    OP_SWP  = 3'b001,
    OP_SET  = 3'b010,
    OP_CLR  = 3'b011,
    OP_RSV  = 3'b100,
    OP_SWPI = 3'b101,
    OP_SETI = 3'b110,
    OP_CLRI = 3'b111
  } csr_op_e;

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_MAX    = 2'd1,
    TGT_LEN    = 2'd2,
    TGT_SHADOW = 2'd3
  } csr_tgt_e;

  localparam int IMM_W  = 5;
  localparam int ADDR_W = 12;
endpackage

// File: rtl/vl_csr_decode.sv
module vl_csr_decode
  import vl_csr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [ADDR_W-1:0] ADDR_MAXLEN     = 12'h7C0,
  parameter logic [ADDR_W-1:0] ADDR_LEN        = 12'h7C1,
  parameter logic [ADDR_W-1:0] ADDR_LEN_SHADOW = 12'h7C2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        op,
  input  logic [XLEN-1:0]   wdata,
  input  logic [IMM_W-1:0]  imm,
  output csr_tgt_e          tgt,
  output logic [1:0]        kind,
  output logic [XLEN-1:0]   operand,
  output logic              wr_en,
  output logic              illegal
);
  logic op_ok;

  always_comb begin
    unique case (addr)
      ADDR_MAXLEN:     tgt = TGT_MAX;
      ADDR_LEN:        tgt = TGT_LEN;
      ADDR_LEN_SHADOW: tgt = TGT_SHADOW;
      default:         tgt = TGT_NONE;
    endcase
  end

  assign op_ok   = (op[1:0] != 2'b00);
  assign kind    = op[1:0];
  assign operand = op[2] ? {{(XLEN-IMM_W){1'b0}}, imm} : wdata;
  assign wr_en   = (kind == 2'b01) || (operand != '0);
  assign illegal = !op_ok || (tgt == TGT_NONE);
endmodule

// File: rtl/vl_csr_modify.sv
module vl_csr_modify #(
  parameter int W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] operand,
  input  logic [1:0]   kind,
  output logic [W-1:0] result
);
  always_comb begin
    unique case (kind)
      2'b10:   result = cur | operand;
      2'b11:   result = cur & ~operand;
      default: result = operand;
    endcase
  end
endmodule

// File: rtl/vl_csr_min.sv
module vl_csr_min #(
  parameter int W  = 32,
  parameter int LW = 6
) (
  input  logic [W-1:0]  value,
  input  logic [LW-1:0] limit,
  output logic [LW-1:0] result
);
  logic [W-1:0] limit_w;

  assign limit_w = {{(W-LW){1'b0}}, limit};
  assign result  = (value > limit_w) ? limit : value[LW-1:0];
endmodule

// File: rtl/vl_csr_unit.sv
module vl_csr_unit
  import vl_csr_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [11:0] ADDR_MAXLEN     = 12'h7C0,
  parameter logic [11:0] ADDR_LEN        = 12'h7C1,
  parameter logic [11:0] ADDR_LEN_SHADOW = 12'h7C2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [11:0]     req_addr,
  input  logic [2:0]      req_op,
  input  logic [XLEN-1:0] req_wdata,
  input  logic [4:0]      req_imm,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_rdata,
  output logic            rsp_illegal
);
  localparam int LW = $clog2(XLEN + 1);
  localparam logic [LW-1:0] LIM_XLEN  = LW'(XLEN);
  localparam logic [LW-1:0] LEN_RESET = LW'(1);

  logic [LW-1:0]   maxvl_q, vl_q, maxvl_d, vl_d;
  logic [XLEN-1:0] rdata_d;
  csr_tgt_e        tgt;
  logic [1:0]      kind;
  logic [XLEN-1:0] operand, cur_val, new_val, vl_wide;
  logic            wr_en, illegal;
  logic [LW-1:0]   max_sat, vl_lowered, len_clamped;

  vl_csr_decode #(
    .XLEN(XLEN), .ADDR_MAXLEN(ADDR_MAXLEN), .ADDR_LEN(ADDR_LEN),
    .ADDR_LEN_SHADOW(ADDR_LEN_SHADOW)
  ) u_dec (
    .addr(req_addr), .op(req_op), .wdata(req_wdata), .imm(req_imm),
    .tgt(tgt), .kind(kind), .operand(operand), .wr_en(wr_en), .illegal(illegal)
  );

  assign vl_wide = {{(XLEN-LW){1'b0}}, vl_q};
  assign cur_val = (tgt == TGT_MAX) ? {{(XLEN-LW){1'b0}}, maxvl_q} : vl_wide;

  vl_csr_modify #(.W(XLEN)) u_mod (
    .cur(cur_val), .operand(operand), .kind(kind), .result(new_val)
  );

  // New ceiling saturates at XLEN.
  vl_csr_min #(.W(XLEN), .LW(LW)) u_sat_max (
    .value(new_val), .limit(LIM_XLEN), .result(max_sat)
  );
  // Current length pulled under a freshly written ceiling.
  vl_csr_min #(.W(XLEN), .LW(LW)) u_lower_len (
    .value(vl_wide), .limit(max_sat), .result(vl_lowered)
  );
  // Length write clamped to the held ceiling.
  vl_csr_min #(.W(XLEN), .LW(LW)) u_clamp_len (
    .value(new_val), .limit(maxvl_q), .result(len_clamped)
  );

  always_comb begin
    maxvl_d = maxvl_q;
    vl_d    = vl_q;
    rdata_d = '0;
    if (req_valid && !illegal) begin
      unique case (tgt)
        TGT_MAX: begin
          rdata_d = {{(XLEN-LW){1'b0}}, maxvl_q};
          if (wr_en) begin
            maxvl_d = max_sat;
            vl_d    = vl_lowered;
          end
        end
        TGT_LEN: begin
          if (wr_en) vl_d = len_clamped;
          rdata_d = {{(XLEN-LW){1'b0}}, vl_d};
        end
        TGT_SHADOW: begin
          rdata_d = vl_wide;
          if (wr_en) vl_d = len_clamped;
        end
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maxvl_q     <= LIM_XLEN;
      vl_q        <= LEN_RESET;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_illegal <= 1'b0;
    end else begin
      maxvl_q     <= maxvl_d;
      vl_q        <= vl_d;
      rsp_valid   <= req_valid;
      rsp_rdata   <= rdata_d;
      rsp_illegal <= req_valid && illegal;
    end
  end
endmodule

// File: rtl/vl_csr_checker.sv
module vl_csr_checker #(
  parameter int XLEN = 32,
  parameter int LW   = 6,
  parameter logic [11:0] ADDR_MAXLEN     = 12'h7C0,
  parameter logic [11:0] ADDR_LEN        = 12'h7C1,
  parameter logic [11:0] ADDR_LEN_SHADOW = 12'h7C2
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [11:0]     req_addr,
  input logic [2:0]      req_op,
  input logic            rsp_valid,
  input logic [XLEN-1:0] rsp_rdata,
  input logic            rsp_illegal,
  input logic [LW-1:0]   maxvl_q,
  input logic [LW-1:0]   vl_q
);
  logic op_legal, addr_legal;
  logic [XLEN-1:0] vl_ext;

  assign op_legal   = (req_op[1:0] != 2'b00);
  assign addr_legal = (req_addr == ADDR_MAXLEN) || (req_addr == ADDR_LEN) ||
                      (req_addr == ADDR_LEN_SHADOW);
  assign vl_ext     = {{(XLEN-LW){1'b0}}, vl_q};

  assert_primary_returns_stored_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid && op_legal && req_addr == ADDR_LEN |=> !rsp_illegal && rsp_rdata == vl_ext);

  assert_shadow_returns_old_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid && op_legal && req_addr == ADDR_LEN_SHADOW |=> rsp_rdata == $past(vl_ext));

  assert_max_within_xlen_R4: assert property (@(posedge clk) disable iff (rst)
    32'(maxvl_q) <= XLEN);

  assert_len_within_max_R5: assert property (@(posedge clk) disable iff (rst)
    vl_q <= maxvl_q);

  assert_illegal_no_change_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid && !(op_legal && addr_legal) |=>
      rsp_illegal && rsp_rdata == '0 && $stable(vl_q) && $stable(maxvl_q));

  assert_resp_follows_req_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_spurious_resp_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_illegal);
endmodule

bind vl_csr_unit vl_csr_checker #(
  .XLEN(XLEN), .LW(LW), .ADDR_MAXLEN(ADDR_MAXLEN), .ADDR_LEN(ADDR_LEN),
  .ADDR_LEN_SHADOW(ADDR_LEN_SHADOW)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_op(req_op), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .rsp_illegal(rsp_illegal), .maxvl_q(maxvl_q), .vl_q(vl_q)
);

// File: tb/vl_csr_unit_tb.sv
module vl_csr_unit_tb;
  localparam int XLEN = 16;
  localparam logic [11:0] A_MAX = 12'h7C0;
  localparam logic [11:0] A_LEN = 12'h7C1;
  localparam logic [11:0] A_SH  = 12'h7C2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic [11:0]     req_addr = '0;
  logic [2:0]      req_op = '0;
  logic [XLEN-1:0] req_wdata = '0;
  logic [4:0]      req_imm = '0;
  logic            rsp_valid;
  logic [XLEN-1:0] rsp_rdata;
  logic            rsp_illegal;

  int checks = 0;
  int failures = 0;
  int m_max = XLEN;
  int m_len = 1;
  bit done = 0;

  vl_csr_unit #(.XLEN(XLEN), .ADDR_MAXLEN(A_MAX), .ADDR_LEN(A_LEN),
                .ADDR_LEN_SHADOW(A_SH)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_op(req_op), .req_wdata(req_wdata), .req_imm(req_imm),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal)
  );

  always #10 clk = ~clk;

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic access(logic [11:0] a, logic [2:0] op, int wv, int imm, string rq);
    int opnd, cur, nv, exp_rd, exp_ill;
    bit we;
    opnd = op[2] ? (imm & 31) : (wv & 32'hFFFF);
    exp_ill = 0;
    exp_rd = 0;
    if (op[1:0] == 2'b00 || !(a == A_MAX || a == A_LEN || a == A_SH)) begin
      exp_ill = 1;
    end else begin
      cur = (a == A_MAX) ? m_max : m_len;
      case (op[1:0])
        2'b01: nv = opnd;
        2'b10: nv = cur | opnd;
        default: nv = cur & ~opnd & 32'hFFFF;
      endcase
      we = (op[1:0] == 2'b01) || (opnd != 0);
      if (a == A_MAX) begin
        exp_rd = m_max;
        if (we) begin m_max = imin(nv, XLEN); m_len = imin(m_len, m_max); end
      end else if (a == A_LEN) begin
        if (we) m_len = imin(nv, m_max);
        exp_rd = m_len;
      end else begin
        exp_rd = m_len;
        if (we) m_len = imin(nv, m_max);
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_op = op;
    req_wdata = wv[XLEN-1:0]; req_imm = imm[4:0];
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    chk({rq, " valid"}, int'(rsp_valid), 1);
    chk({rq, " illegal"}, int'(rsp_illegal), exp_ill);
    chk({rq, " rdata"}, int'(rsp_rdata), exp_rd);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1 rsp_illegal after reset", int'(rsp_illegal), 0);
    access(A_MAX, 3'b010, 0, 0, "R1 ceiling reset");
    access(A_SH, 3'b011, 0, 0, "R1 length reset");

    // R2 R4 R5: sweep ceiling and requested length past XLEN
    for (int m = 0; m <= XLEN + 4; m++) begin
      access(A_MAX, 3'b001, m, 0, "R4 ceiling write");
      access(A_SH, 3'b010, 0, 0, "R5 length under ceiling");
      for (int r = 0; r <= XLEN + 4; r++) begin
        access(A_LEN, 3'b001, r, 0, "R2 primary write");
        access(A_SH, 3'b010, 0, 0, "R3 shadow readback");
      end
    end
    access(A_MAX, 3'b001, 60000, 0, "R4 saturate large");
    access(A_LEN, 3'b001, 12, 0, "R2 exact request");
    access(A_MAX, 3'b001, 5, 0, "R5 lower ceiling");
    access(A_SH, 3'b001, 9, 0, "R3 shadow swap old");
    access(A_SH, 3'b010, 0, 0, "R3 shadow clamp stored");
    access(A_MAX, 3'b001, XLEN, 0, "R4 restore");

    // R8: every immediate, garbage on register operand
    for (int i = 0; i < 32; i++) begin
      access(A_LEN, 3'b101, 16'hFFFF, i, "R8 primary imm");
      access(A_SH, 3'b101, 16'hAAAA, 31 - i, "R8 shadow imm");
      access(A_MAX, 3'b101, 16'h5555, i, "R8 ceiling imm");
    end
    access(A_MAX, 3'b001, XLEN, 0, "R4 restore");

    // R6: set and clear from present contents, then clamped
    for (int b = 0; b <= XLEN; b++) begin
      access(A_SH, 3'b001, b, 0, "R6 seed");
      access(A_LEN, 3'b010, 5, 0, "R6 set");
      access(A_LEN, 3'b011, 2, 0, "R6 clear");
      access(A_LEN, 3'b110, 0, 24, "R6 set imm");
      access(A_LEN, 3'b111, 0, 9, "R6 clear imm");
      access(A_MAX, 3'b011, b, 0, "R6 ceiling clear");
      access(A_MAX, 3'b010, 3, 0, "R6 ceiling set");
    end

    // R7: zero operand set/clear are reads only
    access(A_MAX, 3'b001, 11, 0, "R7 setup");
    access(A_LEN, 3'b001, 7, 0, "R7 setup");
    access(A_LEN, 3'b011, 0, 0, "R7 primary clear zero");
    access(A_LEN, 3'b110, 16'hFFFF, 0, "R7 primary set imm zero");
    access(A_MAX, 3'b010, 0, 0, "R7 ceiling set zero");
    access(A_SH, 3'b111, 16'hFFFF, 0, "R7 shadow clear imm zero");
    access(A_SH, 3'b001, 0, 0, "R7 swap zero writes");
    access(A_SH, 3'b010, 0, 0, "R7 readback");

    // R9: stray addresses and reserved op codes
    access(A_LEN, 3'b001, 6, 0, "R9 setup");
    access(12'h000, 3'b001, 3, 0, "R9 bad addr");
    access(12'h7C3, 3'b101, 0, 1, "R9 bad addr imm");
    access(A_LEN, 3'b000, 2, 0, "R9 op 000");
    access(A_MAX, 3'b100, 1, 1, "R9 op 100");
    access(A_SH, 3'b100, 1, 1, "R9 op 100 shadow");
    access(A_MAX, 3'b010, 0, 0, "R9 ceiling kept");
    access(A_SH, 3'b010, 0, 0, "R9 length kept");

    // R10: idle cycles give no response
    @(negedge clk);
    @(posedge clk); #1;
    chk("R10 idle no valid", int'(rsp_valid), 0);
    @(posedge clk); #1;
    chk("R10 idle no illegal", int'(rsp_illegal), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule